// File: doc/BRIEF.md
# Descriptor-Chained Byte DMA Channel

This block is one DMA channel that copies bytes from a peripheral read port to a memory write port. The work is described by a linked list of transfer descriptors kept in a small on-chip table. Each descriptor has a 12-bit byte count, the index of the descriptor that follows it, a destination address and three control flags. A transfer longer than 4095 bytes is split across several linked descriptors. The last descriptor of a chain can point back to the first, so a fixed buffer is refilled over and over without help from the host.

The host loads descriptors through a one-cycle write port, names the first descriptor and starts the channel. It can read back the live remaining count and the index of the current descriptor, and it can abort the run. Normally each peripheral request moves one byte. A descriptor can also be marked to run on by itself, so that one request drives a whole chain. A descriptor can be marked to pulse a completion output when its last byte lands, and this output is meant to feed an interrupt.

Top module: `chain_dma`

## Requirements
- R1: After reset, busy, done, mem_valid, term_pulse and periph_ack are all 0, and live_count is 0.
- R2: By default each periph_req pulse moves one byte. A descriptor of count N that gets K < N requests writes K bytes, stays busy, and shows live_count = N - K.
- R3: When a descriptor without the auto flag ends and the chain continues, the next descriptor is fetched but writes nothing until a new request arrives.
- R4: The auto flag is desc_wr_flags bit 2. Once one byte of an auto descriptor has moved, its remaining bytes and the first byte of the following descriptor move with no request. A chain made only of auto descriptors completes on one request.
- R5: The terminal flag is desc_wr_flags bit 1. It makes term_pulse high for exactly one cycle, in the cycle after the last byte of that descriptor is accepted. There is one pulse for each flagged descriptor that completes.
- R6: The increment flag is desc_wr_flags bit 0. When it is set, byte k of a descriptor goes to dst + k. When it is clear, every byte goes to dst.
- R7: When the count reaches zero, the descriptor named by the next field is loaded. A next field of all ones (15) ends the chain: busy falls and done rises. Starting a run clears done.
- R8: A descriptor with count 0 is skipped without writing anything, and its next field is followed.
- R9: A chain whose last descriptor links back to its first keeps rewriting the same buffer and raises one terminal pulse on each pass.
- R10: Table indices 14 and 15 are reserved. Descriptor writes to them are ignored, and they always read as count 0 with next = 15. A start that names a reserved index is ignored.
- R11: mem_valid stays high, with mem_addr and mem_data stable, until mem_ready is seen. periph_ack pulses once for each request consumed, in the cycle after the byte it moved is accepted.
- R12: Requests that arrive while a byte is in flight are counted as pending and are never lost. Requests that arrive before a start are discarded by the start.
- R13: chan_stop ends the run. A write already in flight first completes. Afterwards busy is 0 and done stays 0.
- R14: live_idx shows the index of the descriptor being served, and live_count shows its remaining bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr_en | input | 1 | Write one descriptor this cycle |
| desc_wr_idx | input | 4 | Table index to write |
| desc_wr_count | input | 12 | Byte count of the descriptor |
| desc_wr_next | input | 4 | Index of the following descriptor (15 ends the chain) |
| desc_wr_dst | input | 8 | Destination address |
| desc_wr_flags | input | 3 | Bit 2 auto, bit 1 terminal pulse, bit 0 increment |
| chan_start | input | 1 | Start the channel (taken only when idle) |
| chan_start_idx | input | 4 | First descriptor of the run |
| chan_stop | input | 1 | Abort the run |
| busy | output | 1 | Channel running |
| done | output | 1 | Chain reached its end code |
| live_count | output | 12 | Remaining bytes of the current descriptor |
| live_idx | output | 4 | Current descriptor index |
| periph_req | input | 1 | One-cycle byte request |
| periph_data | input | 8 | Byte offered by the peripheral |
| periph_ack | output | 1 | Request served (byte accepted) |
| mem_valid | output | 1 | Memory write pending |
| mem_addr | output | 8 | Write address |
| mem_data | output | 8 | Write data |
| mem_ready | input | 1 | Memory accepts the write |
| term_pulse | output | 1 | Completion pulse of a flagged descriptor |

## Verification
A wrong count or a broken link shows as extra or missing bytes in the modeled memory, or as a done flag that never rises. This is seen one descriptor later at most, because the bench counts every accepted write and compares the last byte of each buffer. If the carried auto credit is wrong, bytes move without requests, or stall when they should move. The bench compares the write count to the number of requests it gave, before and after each boundary between descriptors. Handshake and pulse shape errors show within one cycle and are caught by the bound assertions.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int CNT_W    = 12;
    localparam int IDX_W    = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int NUM_DESC = 1 << IDX_W;

    typedef logic [IDX_W-1:0] idx_t;

    // bit 2 auto, bit 1 terminal pulse, bit 0 destination increment
    typedef struct packed {
        logic auto_next;
        logic term_en;
        logic dst_inc;
    } flags_t;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        idx_t              next;
        logic [ADDR_W-1:0] dst;
        flags_t            flags;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_WRITE, ST_ADV
    } state_e;

    typedef struct packed {
        state_e            st;
        idx_t              idx;
        logic [CNT_W-1:0]  count;
        idx_t              next;
        logic [ADDR_W-1:0] dst;
        flags_t            flags;
        logic [DATA_W-1:0] data;
        logic              run;
        logic              owe_ack;
        logic              stop_pend;
        logic              done;
        logic              term;
        logic              ack;
    } regs_t;
endpackage

// File: rtl/dma_desc_table.sv
module dma_desc_table
    import dma_pkg::*;
#(
    parameter int NUM_RSVD = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  desc_t wr_desc,
    input  idx_t  rd_idx,
    output desc_t rd_desc
);
    localparam int USER_DESC = NUM_DESC - NUM_RSVD;
    localparam desc_t EMPTY = '{count: '0, next: '1, dst: '0, flags: '0};

    desc_t ent [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
        if (g < USER_DESC) begin : g_user
            desc_t ent_d, ent_q;
            always_comb begin
                ent_d = ent_q;
                if (wr_en && (wr_idx == idx_t'(g))) ent_d = wr_desc;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) ent_q <= EMPTY;
                else        ent_q <= ent_d;
            end
            assign ent[g] = ent_q;
        end else begin : g_rsvd
            assign ent[g] = EMPTY;
        end
    end

    assign rd_desc = ent[rd_idx];
endmodule

// File: rtl/dma_req_pend.sv
module dma_req_pend #(
    parameter int PEND_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    logic [PEND_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)                                     cnt_d = '0;
        else if (inc && !dec && (cnt_q != '1))       cnt_d = cnt_q + 1'b1;
        else if (dec && !inc && (cnt_q != '0))       cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nonzero = (cnt_q != '0);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import dma_pkg::*;
#(
    parameter int NUM_RSVD = 2,
    parameter int PEND_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_wr_en,
    input  logic [IDX_W-1:0]  desc_wr_idx,
    input  logic [CNT_W-1:0]  desc_wr_count,
    input  logic [IDX_W-1:0]  desc_wr_next,
    input  logic [ADDR_W-1:0] desc_wr_dst,
    input  logic [2:0]        desc_wr_flags,
    input  logic              chan_start,
    input  logic [IDX_W-1:0]  chan_start_idx,
    input  logic              chan_stop,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  live_count,
    output logic [IDX_W-1:0]  live_idx,
    input  logic              periph_req,
    input  logic [DATA_W-1:0] periph_data,
    output logic              periph_ack,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    input  logic              mem_ready,
    output logic              term_pulse
);
    localparam int           USER_DESC = NUM_DESC - NUM_RSVD;
    localparam logic [IDX_W:0] USER_LIM = (IDX_W+1)'(USER_DESC);
    localparam idx_t         END_IDX   = '1;

    regs_t d, q;
    desc_t wr_desc, rd_desc;
    logic  pend_nz, consume, start_ok;

    assign wr_desc = '{count: desc_wr_count, next: desc_wr_next,
                       dst: desc_wr_dst, flags: flags_t'(desc_wr_flags)};

    dma_desc_table #(.NUM_RSVD(NUM_RSVD)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (desc_wr_en),
        .wr_idx  (desc_wr_idx),
        .wr_desc (wr_desc),
        .rd_idx  (q.idx),
        .rd_desc (rd_desc)
    );

    dma_req_pend #(.PEND_W(PEND_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_ok),
        .inc     (periph_req),
        .dec     (consume),
        .nonzero (pend_nz)
    );

    always_comb begin
        d        = q;
        d.term   = 1'b0;
        d.ack    = 1'b0;
        consume  = 1'b0;
        start_ok = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (chan_start && ({1'b0, chan_start_idx} < USER_LIM)) begin
                    start_ok    = 1'b1;
                    d.st        = ST_FETCH;
                    d.idx       = chan_start_idx;
                    d.done      = 1'b0;
                    d.run       = 1'b0;
                    d.stop_pend = 1'b0;
                end
            end
            ST_FETCH: begin
                if (chan_stop) begin
                    d.st = ST_IDLE;
                end else begin
                    d.count = rd_desc.count;
                    d.next  = rd_desc.next;
                    d.dst   = rd_desc.dst;
                    d.flags = rd_desc.flags;
                    d.st    = (rd_desc.count == '0) ? ST_ADV : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (chan_stop) begin
                    d.st = ST_IDLE;
                end else if (q.run || pend_nz) begin
                    d.data    = periph_data;
                    d.owe_ack = !q.run;
                    consume   = !q.run;
                    d.st      = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (chan_stop) d.stop_pend = 1'b1;
                if (mem_ready) begin
                    d.count = q.count - 1'b1;
                    if (q.flags.dst_inc) d.dst = q.dst + 1'b1;
                    d.ack = q.owe_ack;
                    d.run = q.flags.auto_next;
                    if (q.count == CNT_W'(1)) begin
                        d.term = q.flags.term_en;
                        d.st   = ST_ADV;
                    end else begin
                        d.st   = ST_WAIT;
                    end
                    if (chan_stop || q.stop_pend) d.st = ST_IDLE;
                end
            end
            ST_ADV: begin
                if (chan_stop) begin
                    d.st = ST_IDLE;
                end else if (q.next == END_IDX) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.next;
                    d.st  = ST_FETCH;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = (q.st != ST_IDLE);
    assign done       = q.done;
    assign live_count = q.count;
    assign live_idx   = q.idx;
    assign periph_ack = q.ack;
    assign mem_valid  = (q.st == ST_WRITE);
    assign mem_addr   = q.dst;
    assign mem_data   = q.data;
    assign term_pulse = q.term;
endmodule

// File: rtl/dma_checker.sv
module dma_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       mem_valid,
    input logic       mem_ready,
    input logic [7:0] mem_addr,
    input logic [7:0] mem_data,
    input logic       term_pulse,
    input logic       periph_ack
);
    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    a_r11_ack_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |-> $past(mem_valid && mem_ready));

    a_r5_term_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |=> !term_pulse);

    a_r5_term_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        term_pulse |-> $past(mem_valid && mem_ready));

    a_r7_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r13_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);
endmodule

bind chain_dma dma_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .term_pulse (term_pulse),
    .periph_ack (periph_ack)
);

// File: tb/tb_chain_dma.sv
`timescale 1ns/1ps
module tb_chain_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_wr_en = 1'b0;
    logic [3:0]  desc_wr_idx = '0;
    logic [11:0] desc_wr_count = '0;
    logic [3:0]  desc_wr_next = '0;
    logic [7:0]  desc_wr_dst = '0;
    logic [2:0]  desc_wr_flags = '0;
    logic        chan_start = 1'b0;
    logic [3:0]  chan_start_idx = '0;
    logic        chan_stop = 1'b0;
    logic        busy, done, periph_ack, mem_valid, mem_ready, term_pulse;
    logic [11:0] live_count;
    logic [3:0]  live_idx;
    logic        periph_req = 1'b0;
    logic [7:0]  periph_data;
    logic [7:0]  mem_addr, mem_data;

    always #2 clk = ~clk;   // 250 MHz

    chain_dma dut (
        .clk(clk), .rst_n(rst_n),
        .desc_wr_en(desc_wr_en), .desc_wr_idx(desc_wr_idx), .desc_wr_count(desc_wr_count),
        .desc_wr_next(desc_wr_next), .desc_wr_dst(desc_wr_dst), .desc_wr_flags(desc_wr_flags),
        .chan_start(chan_start), .chan_start_idx(chan_start_idx), .chan_stop(chan_stop),
        .busy(busy), .done(done), .live_count(live_count), .live_idx(live_idx),
        .periph_req(periph_req), .periph_data(periph_data), .periph_ack(periph_ack),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_ready(mem_ready), .term_pulse(term_pulse)
    );

    // memory and event model
    logic [7:0] mem [256];
    logic [7:0] seq = '0;
    int nwr = 0, nterm = 0, nack = 0, cyc = 0;
    logic stall_mode = 1'b0;
    assign periph_data = seq;
    assign mem_ready   = !stall_mode || (cyc % 3 == 0);

    initial for (int i = 0; i < 256; i++) mem[i] = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_valid && mem_ready) begin
            mem[mem_addr] <= mem_data;
            nwr <= nwr + 1;
            seq <= seq + 1'b1;
        end
        if (term_pulse) nterm <= nterm + 1;
        if (periph_ack) nack  <= nack + 1;
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lim);
        n_cmp++;
        if (act < lim) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    task automatic wr_desc(input int idx, input int cnt, input int nxt, input int dst, input int flg);
        @(negedge clk);
        desc_wr_en = 1'b1; desc_wr_idx = 4'(idx); desc_wr_count = 12'(cnt);
        desc_wr_next = 4'(nxt); desc_wr_dst = 8'(dst); desc_wr_flags = 3'(flg);
        @(negedge clk);
        desc_wr_en = 1'b0;
    endtask

    task automatic start(input int idx);
        @(negedge clk);
        chan_start = 1'b1; chan_start_idx = 4'(idx);
        @(negedge clk);
        chan_start = 1'b0;
    endtask

    task automatic stop_chan();
        @(negedge clk);
        chan_stop = 1'b1;
        @(negedge clk);
        chan_stop = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic reqs(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            periph_req = 1'b1;
            @(negedge clk);
            periph_req = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // single-descriptor vectors; flags: bit0 inc, bit1 term, bit2 auto
    localparam int NV = 6;
    localparam int V_CNT  [NV] = '{4, 5, 3, 6, 0, 2};
    localparam int V_FLG  [NV] = '{1, 3, 6, 5, 7, 3};
    localparam int V_REQ  [NV] = '{4, 3, 1, 1, 0, 5};
    localparam int V_WR   [NV] = '{4, 3, 3, 6, 0, 2};
    localparam int V_TERM [NV] = '{0, 0, 1, 0, 0, 1};
    localparam int V_DONE [NV] = '{1, 0, 1, 1, 1, 1};

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int w0, t0, a0, dst, last;
        logic [7:0] s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_valid", mem_valid, 0);
        chk("R1 term_pulse", term_pulse, 0);
        chk("R1 periph_ack", periph_ack, 0);
        chk("R1 live_count", live_count, 0);

        // vector table: R2 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            dst = 16 + v * 8;
            wr_desc(0, V_CNT[v], 15, dst, V_FLG[v]);
            w0 = nwr; t0 = nterm; s0 = seq;
            start(0);
            reqs(V_REQ[v], 6);
            settle(40);
            chk($sformatf("R2 v%0d writes", v), nwr - w0, V_WR[v]);
            chk($sformatf("R5 v%0d terms", v), nterm - t0, V_TERM[v]);
            chk($sformatf("R7 v%0d done", v), done, V_DONE[v]);
            chk($sformatf("R14 v%0d live_count", v), live_count, V_CNT[v] - V_WR[v]);
            if (V_WR[v] > 0) begin
                last = (V_FLG[v] & 1) ? dst + V_WR[v] - 1 : dst;
                chk($sformatf("R6 v%0d last byte", v), mem[last], 32'(8'(s0 + 8'(V_WR[v] - 1))));
            end
            if (V_DONE[v] == 0) begin
                stop_chan();
                chk("R13 stop busy", busy, 0);
                chk("R13 stop done", done, 0);
            end
        end

        // R3 R14 request-gated advance across a link
        wr_desc(1, 2, 2, 8'hA0, 1);
        wr_desc(2, 2, 15, 8'hA8, 1);
        w0 = nwr; s0 = seq;
        start(1);
        reqs(2, 6);
        settle(20);
        chk("R3 writes before new request", nwr - w0, 2);
        chk("R3 still busy", busy, 1);
        chk("R14 live_idx", live_idx, 2);
        chk("R14 live_count", live_count, 2);
        reqs(2, 6);
        settle(20);
        chk("R7 chain writes", nwr - w0, 4);
        chk("R7 chain done", done, 1);
        chk("R7 second descriptor data", mem[8'hA9], 32'(8'(s0 + 8'd3)));

        // R4 all-auto chain on one request, with terminal on the last
        wr_desc(3, 3, 4, 8'hB0, 5);
        wr_desc(4, 2, 15, 8'hB8, 7);
        w0 = nwr; t0 = nterm;
        start(3);
        reqs(1, 0);
        settle(40);
        chk("R4 auto chain writes", nwr - w0, 5);
        chk("R4 auto chain done", done, 1);
        chk("R5 auto chain terms", nterm - t0, 1);

        // R4 credit carried into a non-auto descriptor
        wr_desc(5, 2, 6, 8'hC0, 4);
        wr_desc(6, 3, 15, 8'hC8, 1);
        w0 = nwr; a0 = nack; s0 = seq;
        start(5);
        reqs(1, 0);
        settle(40);
        chk("R4 carry writes", nwr - w0, 3);
        chk("R4 carry busy", busy, 1);
        chk("R6 fixed address", mem[8'hC0], 32'(8'(s0 + 8'd1)));
        reqs(2, 6);
        settle(20);
        chk("R4 carry total", nwr - w0, 5);
        chk("R11 ack count", nack - a0, 3);

        // R8 zero-count descriptor in a chain
        wr_desc(7, 0, 8, 8'hD0, 1);
        wr_desc(8, 1, 15, 8'hD0, 1);
        w0 = nwr;
        start(7);
        reqs(1, 0);
        settle(20);
        chk("R8 skip writes", nwr - w0, 1);
        chk("R8 skip done", done, 1);

        // R10 reserved entries
        wr_desc(14, 5, 15, 8'hD8, 5);
        wr_desc(9, 1, 14, 8'hD8, 1);
        w0 = nwr;
        start(9);
        reqs(4, 4);
        settle(20);
        chk("R10 reserved write ignored", nwr - w0, 1);
        chk("R10 reserved reads empty", done, 1);
        start(14);
        settle(3);
        chk("R10 reserved start ignored", busy, 0);

        // R9 R13 loop-back then abort
        wr_desc(10, 3, 10, 8'hE0, 7);
        t0 = nterm;
        start(10);
        reqs(1, 0);
        settle(80);
        chk_ge("R9 loop passes", nterm - t0, 3);
        chk("R9 loop still busy", busy, 1);
        stop_chan();
        chk("R13 abort busy", busy, 0);
        chk("R13 abort done", done, 0);
        chk("R9 stays inside buffer", mem[8'hE3], 0);

        // R11 backpressure
        stall_mode = 1'b1;
        wr_desc(11, 4, 15, 8'hE8, 5);
        w0 = nwr; a0 = nack; s0 = seq;
        start(11);
        reqs(1, 0);
        settle(60);
        chk("R11 stalled writes", nwr - w0, 4);
        chk("R11 stalled last byte", mem[8'hEB], 32'(8'(s0 + 8'd3)));
        chk("R11 one ack per request", nack - a0, 1);
        stall_mode = 1'b0;

        // R12 requests back to back while busy
        wr_desc(12, 4, 15, 8'hF0, 1);
        w0 = nwr; a0 = nack;
        start(12);
        reqs(4, 0);
        settle(40);
        chk("R12 pending writes", nwr - w0, 4);
        chk("R12 pending acks", nack - a0, 4);
        chk("R12 pending done", done, 1);

        // R12 stale requests cleared by start
        wr_desc(13, 2, 15, 8'hF8, 1);
        reqs(2, 0);
        w0 = nwr;
        start(13);
        settle(20);
        chk("R12 stale requests dropped", nwr - w0, 0);
        chk("R12 waiting busy", busy, 1);
        stop_chan();

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule